// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the fetch address for a 32-bit instruction stream in which every control transfer has one delay slot. It holds two registers: the address of the instruction now issuing (`fetch_pc`) and the address that will issue after it. On each advance the first register takes the value of the second. The second register then takes either the sequential successor or the target of the transfer now issuing. As a result, the instruction placed after a call, branch or jump always runs before the target is reached.

The decoder supplies an instruction class together with a 4-bit test selector, the displacement fields, a register-computed jump address, a trap vector and the current flags N, Z, V and C. From these the block decides whether the transfer is taken and computes its target. For calls and jump-and-link it also supplies the address of the transfer instruction as the link value. A trap-on-condition that is taken jumps straight to the vector and has no delay slot. Annulment of the delay slot is not handled here.

Top module: `dbpc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fetch_pc` becomes `RESET_PC` (default 0) and the following address becomes `RESET_PC`+4. The first two advances after reset therefore show `RESET_PC`+4 and then `RESET_PC`+8.
- R2: On an edge with `step` high and a class that transfers nothing (code 0, or any code from 5 to 7), `fetch_pc` takes the old next address, and the next address advances by 4.
- R3: On an edge with `step` low, `fetch_pc` and the next address keep their values, whatever the other inputs are.
- R4: A call (class 1) at address A loads the next address with A + sign-extended `disp30`×4, modulo 2^32. `fetch_pc` then shows A+4 (the delay slot), followed by the target.
- R5: A branch (class 2) at address A whose test holds loads the next address with A + sign-extended `disp22`×4. If its test fails, the sequence continues as in R2.
- R6: The test selected by `cond` uses `icc` = {N,Z,V,C}. `cond[2:0]` picks a base test: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V. `cond[3]` inverts the result, so 8 is always, 9 is not-equal, 10 is signed greater, 11 is signed greater-or-equal, 12 is unsigned greater, 13 is carry clear, 14 is positive and 15 is overflow clear.
- R7: Jump-and-link (class 3) is always taken and loads the next address with `jump_tgt`.
- R8: `link_valid` is high exactly when the class is call or jump-and-link. `link_addr` always equals the current `fetch_pc`.
- R9: A trap-on-condition (class 4) whose test holds drives `trap_taken` high in the same cycle. On the advance, `fetch_pc` takes `trap_vec` and the next address takes `trap_vec`+4. If the test fails, `trap_taken` stays low and the sequence continues as in R2.
- R10: A transfer placed in the delay slot of another transfer takes its displacement relative to its own address. It redirects the stream after the first target has issued once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Advance the sequencer on this edge |
| op_class | input | 3 | 0 none, 1 call, 2 branch, 3 jump-and-link, 4 trap-on-condition |
| cond | input | 4 | Test selector for branch and trap |
| disp30 | input | 30 | Call word displacement |
| disp22 | input | 22 | Branch word displacement |
| jump_tgt | input | 32 | Register-computed jump address |
| trap_vec | input | 32 | Trap vector address |
| icc | input | 4 | Flags {N,Z,V,C} |
| fetch_pc | output | 32 | Address of the instruction now issuing |
| link_addr | output | 32 | Return value for link writes |
| link_valid | output | 1 | Current class writes a link value |
| trap_taken | output | 1 | Current trap-on-condition is taken |

## Verification
The bench targets the following corner cases:
- Displacements at their most negative and most positive values, and ones that wrap past address zero. A design that dropped or mis-sized the sign extension would jump forward instead of back.
- A branch placed in the delay slot of another branch. A design that computed displacements from the next address would land 4 bytes off.
- Each of the 16 test codes, driven against random flags. A swapped signed/unsigned pair or a missing inversion would show up as a taken/not-taken mismatch.
- Traps, both taken and not taken. A trap that kept a delay slot would fetch the old next address before the vector.
- Stalls with live transfer inputs. A design that stalled wrongly would move `fetch_pc`.

// File: rtl/dbpc_pkg.sv
package dbpc_pkg;
    // Instruction class codes presented by the decoder
    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_CALL   = 3'd1,
        CLS_BRANCH = 3'd2,
        CLS_JMPL   = 3'd3,
        CLS_TRAP   = 3'd4
    } cls_e;

    // Flag positions inside the 4-bit flags bus
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
endpackage

// File: rtl/dbpc_cond_eval.sv
// dbpc_cond_eval: evaluates the 4-bit test selector against the flags.
// Assumes flags = {N,Z,V,C}; bit 3 of the selector inverts the base test.
module dbpc_cond_eval
    import dbpc_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       hit
);
    logic n_f, z_f, v_f, c_f;
    logic base;

    assign n_f = flags[FLG_N];
    assign z_f = flags[FLG_Z];
    assign v_f = flags[FLG_V];
    assign c_f = flags[FLG_C];

    // Select the base test from the low three selector bits
    always_comb begin
        unique case (cond[2:0])
            3'd0:    base = 1'b0;
            3'd1:    base = z_f;
            3'd2:    base = z_f | (n_f ^ v_f);
            3'd3:    base = n_f ^ v_f;
            3'd4:    base = c_f | z_f;
            3'd5:    base = c_f;
            3'd6:    base = n_f;
            default: base = v_f;
        endcase
    end

    assign hit = base ^ cond[3];
endmodule

// File: rtl/dbpc_target_calc.sv
// dbpc_target_calc: forms the redirect address for the issuing transfer.
// Assumes displacements are word counts relative to the transfer's own
// address and that ADDR_W exceeds both displacement widths.
module dbpc_target_calc
    import dbpc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CALL_DISP_W = 30,
    parameter int BR_DISP_W   = 22
) (
    input  logic [ADDR_W-1:0]      cur_pc,
    input  logic [2:0]             cls,
    input  logic [CALL_DISP_W-1:0] call_disp,
    input  logic [BR_DISP_W-1:0]   br_disp,
    input  logic [ADDR_W-1:0]      reg_tgt,
    output logic [ADDR_W-1:0]      tgt
);
    localparam int CALL_EXT = ADDR_W - CALL_DISP_W;
    localparam int BR_EXT   = ADDR_W - BR_DISP_W;

    logic [ADDR_W-1:0] call_off;
    logic [ADDR_W-1:0] br_off;

    // Sign-extend then scale the call displacement to bytes
    generate
        if (CALL_EXT >= 1) begin : g_call_ext
            assign call_off = {{CALL_EXT{call_disp[CALL_DISP_W-1]}}, call_disp} << 2;
        end else begin : g_call_trunc
            assign call_off = call_disp[ADDR_W-1:0] << 2;
        end
    endgenerate

    // Sign-extend then scale the branch displacement to bytes
    assign br_off = {{BR_EXT{br_disp[BR_DISP_W-1]}}, br_disp} << 2;

    // Pick the target for the current class
    always_comb begin
        unique case (cls)
            CLS_CALL:   tgt = cur_pc + call_off;
            CLS_BRANCH: tgt = cur_pc + br_off;
            CLS_JMPL:   tgt = reg_tgt;
            default:    tgt = '0;
        endcase
    end
endmodule

// File: rtl/dbpc_seq_regs.sv
// dbpc_seq_regs: holds the issuing address and the following address.
// Assumes redirect and trap_load are mutually exclusive; trap_load wins.
module dbpc_seq_regs #(
    parameter int              ADDR_W   = 32,
    parameter logic [31:0]     RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_tgt,
    input  logic              trap_load,
    input  logic [ADDR_W-1:0] vec,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] npc_q
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] RST_PC = RESET_PC[ADDR_W-1:0];

    // Update the address pair on each advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= RST_PC;
            npc_q <= RST_PC + STRIDE;
        end else if (advance) begin
            if (trap_load) begin
                pc_q  <= vec;
                npc_q <= vec + STRIDE;
            end else begin
                pc_q  <= npc_q;
                npc_q <= redirect ? redirect_tgt : (npc_q + STRIDE);
            end
        end
    end
endmodule

// File: rtl/dbpc_unit.sv
// dbpc_unit: delayed-branch fetch address sequencer.
// Assumes one instruction issues per step and that op_class/cond/fields
// describe the instruction at fetch_pc.
module dbpc_unit
    import dbpc_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          CALL_DISP_W = 30,
    parameter int          BR_DISP_W   = 22,
    parameter logic [31:0] RESET_PC    = 32'h0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic [2:0]             op_class,
    input  logic [3:0]             cond,
    input  logic [CALL_DISP_W-1:0] disp30,
    input  logic [BR_DISP_W-1:0]   disp22,
    input  logic [ADDR_W-1:0]      jump_tgt,
    input  logic [ADDR_W-1:0]      trap_vec,
    input  logic [3:0]             icc,
    output logic [ADDR_W-1:0]      fetch_pc,
    output logic [ADDR_W-1:0]      link_addr,
    output logic                   link_valid,
    output logic                   trap_taken
);
    logic              cond_hit;
    logic              redirect;
    logic [ADDR_W-1:0] tgt;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] npc_q;

    dbpc_cond_eval u_cond (
        .cond  (cond),
        .flags (icc),
        .hit   (cond_hit)
    );

    dbpc_target_calc #(
        .ADDR_W      (ADDR_W),
        .CALL_DISP_W (CALL_DISP_W),
        .BR_DISP_W   (BR_DISP_W)
    ) u_tgt (
        .cur_pc    (pc_q),
        .cls       (op_class),
        .call_disp (disp30),
        .br_disp   (disp22),
        .reg_tgt   (jump_tgt),
        .tgt       (tgt)
    );

    // Decide whether the issuing instruction redirects the stream
    always_comb begin
        unique case (op_class)
            CLS_CALL, CLS_JMPL: redirect = 1'b1;
            CLS_BRANCH:         redirect = cond_hit;
            default:            redirect = 1'b0;
        endcase
    end

    assign trap_taken = (op_class == CLS_TRAP) && cond_hit;
    assign link_valid = (op_class == CLS_CALL) || (op_class == CLS_JMPL);
    assign link_addr  = pc_q;
    assign fetch_pc   = pc_q;

    dbpc_seq_regs #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance      (step),
        .redirect     (redirect),
        .redirect_tgt (tgt),
        .trap_load    (trap_taken),
        .vec          (trap_vec),
        .pc_q         (pc_q),
        .npc_q        (npc_q)
    );
endmodule

// File: rtl/dbpc_checker.sv
// dbpc_checker: temporal properties of the sequencer, bound to dbpc_unit.
// Assumes it observes the internal following-address register npc_q.
module dbpc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic [2:0]        op_class,
    input logic [ADDR_W-1:0] trap_vec,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] npc_q,
    input logic              link_valid,
    input logic              trap_taken
);
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(fetch_pc) && $stable(npc_q)));

    a_r2_pc_takes_next: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trap_taken) |=> (fetch_pc == $past(npc_q)));

    a_r9_trap_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (step && trap_taken) |=> (fetch_pc == $past(trap_vec)
                                  && npc_q == $past(trap_vec) + ADDR_W'(4)));

    a_r9_trap_class_only: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (op_class == 3'd4));

    a_r8_link_class: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> (op_class == 3'd1 || op_class == 3'd3));
endmodule

bind dbpc_unit dbpc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .op_class   (op_class),
    .trap_vec   (trap_vec),
    .fetch_pc   (fetch_pc),
    .npc_q      (npc_q),
    .link_valid (link_valid),
    .trap_taken (trap_taken)
);

// File: tb/sim_dbpc_unit.sv
module sim_dbpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic [3:0]  cond = 4'd0;
    logic [29:0] disp30 = '0;
    logic [21:0] disp22 = '0;
    logic [31:0] jump_tgt = '0;
    logic [31:0] trap_vec = '0;
    logic [3:0]  icc = 4'd0;
    logic [31:0] fetch_pc, link_addr;
    logic        link_valid, trap_taken;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] m_pc, m_npc;

    always #4 clk = ~clk;

    dbpc_unit u0 (
        .clk(clk), .rst_n(rst_n), .step(step), .op_class(op_class),
        .cond(cond), .disp30(disp30), .disp22(disp22), .jump_tgt(jump_tgt),
        .trap_vec(trap_vec), .icc(icc), .fetch_pc(fetch_pc),
        .link_addr(link_addr), .link_valid(link_valid), .trap_taken(trap_taken)
    );

    // Reference test table per R6, flags {N,Z,V,C}
    function automatic logic test_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, v, cy;
        {n, z, v, cy} = f;
        case (c)
            4'd0:  return 1'b0;
            4'd8:  return 1'b1;
            4'd1:  return z;
            4'd9:  return !z;
            4'd2:  return z || (n != v);
            4'd10: return !z && (n == v);
            4'd3:  return n != v;
            4'd11: return n == v;
            4'd4:  return cy || z;
            4'd12: return !cy && !z;
            4'd5:  return cy;
            4'd13: return !cy;
            4'd6:  return n;
            4'd14: return !n;
            4'd7:  return v;
            default: return !v;
        endcase
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one instruction, check outputs mid-cycle, then advance the model
    task automatic issue(input logic [2:0] cls, input logic [3:0] c,
                         input logic [29:0] d30, input logic [21:0] d22,
                         input logic [31:0] jt, input logic [31:0] tv,
                         input logic [3:0] f, input logic st, input string req);
        logic hit, exp_trap, exp_link;
        logic [31:0] tgt;
        logic redir;
        @(negedge clk);
        op_class = cls; cond = c; disp30 = d30; disp22 = d22;
        jump_tgt = jt; trap_vec = tv; icc = f; step = st;
        #1;
        hit = test_ok(c, f);
        exp_trap = (cls == 3'd4) && hit;
        exp_link = (cls == 3'd1) || (cls == 3'd3);
        check(fetch_pc === m_pc, req, fetch_pc, m_pc);
        check(trap_taken === exp_trap, "R9 trap_taken", {31'd0, trap_taken}, {31'd0, exp_trap});
        check(link_valid === exp_link, "R8 link_valid", {31'd0, link_valid}, {31'd0, exp_link});
        if (exp_link)
            check(link_addr === m_pc, "R8 link_addr", link_addr, m_pc);
        redir = 1'b0; tgt = '0;
        case (cls)
            3'd1: begin redir = 1'b1; tgt = m_pc + {d30, 2'b00}; end
            3'd2: begin redir = hit; tgt = m_pc + {{8{d22[21]}}, d22, 2'b00}; end
            3'd3: begin redir = 1'b1; tgt = jt; end
            default: ;
        endcase
        if (st) begin
            if (exp_trap) begin
                m_pc = tv; m_npc = tv + 32'd4;
            end else begin
                m_pc = m_npc; m_npc = redir ? tgt : m_npc + 32'd4;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pc = 32'h0; m_npc = 32'h4;
        #1 check(fetch_pc === 32'h0, "R1 reset pc", fetch_pc, 32'h0);
        // R1: two plain advances
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R1 first");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R1 second");
        issue(3'd6, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R2 unused class");
        // R4: call with negative displacement wrapping below zero
        issue(3'd1, 4'd0, 30'h3FFF_FFF0, '0, '0, '0, 4'd0, 1'b1, "R4 call issue");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R4 delay slot");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R4 target");
        // R3: stall with a live call on the inputs
        issue(3'd1, 4'd0, 30'h100, '0, '0, '0, 4'd0, 1'b0, "R3 stall");
        issue(3'd3, 4'd0, '0, '0, 32'h8000_0000, '0, 4'd0, 1'b0, "R3 stall again");
        // R5/R10: branch most negative, then branch in its delay slot
        issue(3'd2, 4'd8, '0, 22'h20_0000, '0, '0, 4'd0, 1'b1, "R5 branch max neg");
        issue(3'd2, 4'd1, '0, 22'h1F_FFFF, '0, '0, 4'b0100, 1'b1, "R10 branch in slot");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R10 first target");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R10 second target");
        // R5: never-branch falls through
        issue(3'd2, 4'd0, '0, 22'h10, '0, '0, 4'hF, 1'b1, "R5 never");
        // R7: jump-and-link
        issue(3'd3, 4'd0, '0, '0, 32'h0000_4000, '0, 4'd0, 1'b1, "R7 jmpl");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R7 slot");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R7 target");
        // R9: trap not taken, then taken
        issue(3'd4, 4'd7, '0, '0, '0, 32'h0000_0800, 4'd0, 1'b1, "R9 trap not taken");
        issue(3'd4, 4'd7, '0, '0, '0, 32'h0000_0800, 4'b0010, 1'b1, "R9 trap taken");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R9 at vector");
        issue(3'd0, 4'd0, '0, '0, '0, '0, 4'd0, 1'b1, "R9 vector plus 4");
        // R6: every test code against every flag set, via branches
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                issue(3'd2, 4'(c), '0, 22'h3, '0, '0, 4'(f), 1'b1, "R6 cond table");
        // Random mix covering R2..R10
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] cls;
            cls = 3'($urandom_range(0, 7));
            issue(cls, 4'($urandom), 30'($urandom), 22'($urandom),
                  {$urandom} & 32'hFFFF_FFFC, {$urandom} & 32'hFFFF_FFFC,
                  4'($urandom), ($urandom_range(0, 7) != 0), "R2 R10 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule